// File: doc/BRIEF.md
# Byte-to-Word Bus Bridge

This block lets a processor with an 8-bit data bus talk to a peripheral that can only be accessed 16 bits at a time. The processor reaches one 16-bit device word through two byte accesses in a row. The first access always carries the low byte and the second always carries the high byte. A single byte of holding storage carries the other half between the two accesses.

On a read, the whole device word is fetched during the low-byte access. The low half goes straight to the processor and the high half is parked in the holding register. The high-byte access is then answered from that register, and the device is not touched. On a write, the low byte is parked first. The device write is issued only when the high byte arrives, with the parked byte as the low half and the live processor byte as the high half. If a high-byte write arrives with no low byte waiting, no device write is issued and a sticky error flag is raised.

An access is recognised on the first clock in which both chip select and strobe are high. A strobe that stays high for several clocks counts as one access.

Top module: `bridge_8to16`

## Requirements
- R1: An access is recognised on the first clock in which `cpu_cs` and `cpu_stb` are both high. A low-byte read (`cpu_rw`=1, `cpu_a0`=0) raises `dev_rd` in that clock, drives `dev_rdata[7:0]` onto `cpu_rdata`, and stores `dev_rdata[15:8]` in the holding register at the end of that clock.
- R2: A high-byte read (`cpu_rw`=1, `cpu_a0`=1) does not raise `dev_rd`. It returns the holding register on `cpu_rdata`.
- R3: A low-byte write (`cpu_rw`=0, `cpu_a0`=0) stores `cpu_wdata` in the holding register, marks a write as pending, and does not raise `dev_wr`.
- R4: A high-byte write (`cpu_rw`=0, `cpu_a0`=1) with a write pending raises `dev_wr` for that clock and clears the pending mark. During that clock, `dev_wdata[15:8]` equals `cpu_wdata` and `dev_wdata[7:0]` equals the stored low byte.
- R5: A high-byte write with no write pending does not raise `dev_wr`. It sets `err_orphan`, which then stays high until reset.
- R6: `dev_rd` and `dev_wr` are never high in the same clock, and each is high for exactly one clock per access. A strobe held high does not repeat the access.
- R7: A synchronous reset clears the holding register, the pending-write mark and `err_orphan`. Any half-written transfer is discarded.
- R8: `cpu_rdata_oe` is high only while `cpu_cs`, `cpu_rw` and `cpu_stb` are all high. Whenever it is low, `cpu_rdata` is zero.
- R9: A low-byte read that arrives while a write is pending cancels that write, so a later high-byte write is treated as having no write pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cs | input | 1 | Processor chip select |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_a0 | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| cpu_stb | input | 1 | Processor access strobe |
| cpu_wdata | input | 8 | Byte written by the processor |
| cpu_rdata | output | 8 | Byte returned to the processor |
| cpu_rdata_oe | output | 1 | Read data enable toward the processor bus |
| dev_rdata | input | 16 | Word presented by the peripheral |
| dev_wdata | output | 16 | Word written to the peripheral |
| dev_rd | output | 1 | One-clock device read strobe |
| dev_wr | output | 1 | One-clock device write strobe |
| err_orphan | output | 1 | Sticky flag: high-byte write arrived with no low byte pending |

## Verification
The assertions assume the peripheral holds `dev_rdata` steady for the whole clock in which `dev_rd` is high. The stimulus changes it only just after a rising edge. The assertions also assume that an access ends before another one begins. The stimulus therefore always drops chip select and strobe for at least one clock between accesses. It mixes paired, reversed, orphaned and cancelled sequences, strobes that are held for several clocks, strobes without chip select, and a reset in the middle of a transfer.

// File: rtl/br_pkg.sv
package br_pkg;

    // Kind of processor access recognised in the current clock.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_RD_LO,
        ACC_RD_HI,
        ACC_WR_LO,
        ACC_WR_HI
    } acc_e;

    // Map a recognised access to its kind; rw=1 is a read, a0=1 the high byte.
    function automatic acc_e classify(input logic fire, input logic rw, input logic a0);
        acc_e k;
        if (!fire) begin
            k = ACC_NONE;
        end else begin
            case ({rw, a0})
                2'b10:   k = ACC_RD_LO;
                2'b11:   k = ACC_RD_HI;
                2'b00:   k = ACC_WR_LO;
                default: k = ACC_WR_HI;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/br_access_decode.sv
module br_access_decode
    import br_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic stb,
    input  logic rw,
    input  logic a0,
    output acc_e acc
);
    logic sel;
    logic sel_q;
    logic fire;

    assign sel  = cs & stb;
    assign fire = !rst && sel && !sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel;
    end

    assign acc = classify(fire, rw, a0);
endmodule

// File: rtl/br_hold_reg.sv
module br_hold_reg
    import br_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic [BYTE_W-1:0] dev_hi,
    input  logic [BYTE_W-1:0] cpu_byte,
    output logic [BYTE_W-1:0] hold_q,
    output logic              err_q,
    output logic              rd_go,
    output logic              wr_go
);
    logic pend_q;

    assign rd_go = (acc == ACC_RD_LO);
    assign wr_go = (acc == ACC_WR_HI) && pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            case (acc)
                ACC_RD_LO: begin
                    hold_q <= dev_hi;
                    pend_q <= 1'b0;
                end
                ACC_WR_LO: begin
                    hold_q <= cpu_byte;
                    pend_q <= 1'b1;
                end
                ACC_WR_HI: begin
                    if (pend_q) pend_q <= 1'b0;
                    else        err_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/br_read_mux.sv
module br_read_mux #(
    parameter int BYTE_W = 8
) (
    input  logic              cs,
    input  logic              rw,
    input  logic              stb,
    input  logic              a0,
    input  logic [BYTE_W-1:0] hold,
    input  logic [BYTE_W-1:0] dev_lo,
    output logic [BYTE_W-1:0] rdata,
    output logic              oe
);
    always_comb begin
        oe    = cs & rw & stb;
        rdata = '0;
        if (oe) rdata = a0 ? hold : dev_lo;
    end
endmodule

// File: rtl/bridge_8to16.sv
module bridge_8to16
    import br_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_cs,
    input  logic              cpu_rw,
    input  logic              cpu_a0,
    input  logic              cpu_stb,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              cpu_rdata_oe,
    input  logic [WORD_W-1:0] dev_rdata,
    output logic [WORD_W-1:0] dev_wdata,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic              err_orphan
);
    acc_e              acc;
    logic [BYTE_W-1:0] hold_q;

    br_access_decode u_dec (
        .clk (clk),
        .rst (rst),
        .cs  (cpu_cs),
        .stb (cpu_stb),
        .rw  (cpu_rw),
        .a0  (cpu_a0),
        .acc (acc)
    );

    br_hold_reg #(.BYTE_W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .dev_hi   (dev_rdata[WORD_W-1:BYTE_W]),
        .cpu_byte (cpu_wdata),
        .hold_q   (hold_q),
        .err_q    (err_orphan),
        .rd_go    (dev_rd),
        .wr_go    (dev_wr)
    );

    br_read_mux #(.BYTE_W(BYTE_W)) u_rmux (
        .cs     (cpu_cs),
        .rw     (cpu_rw),
        .stb    (cpu_stb),
        .a0     (cpu_a0),
        .hold   (hold_q),
        .dev_lo (dev_rdata[BYTE_W-1:0]),
        .rdata  (cpu_rdata),
        .oe     (cpu_rdata_oe)
    );

    assign dev_wdata = {cpu_wdata, hold_q};
endmodule

// File: rtl/br_checker.sv
module br_checker #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_cs,
    input logic              cpu_rw,
    input logic              cpu_a0,
    input logic              cpu_stb,
    input logic [BYTE_W-1:0] cpu_wdata,
    input logic [BYTE_W-1:0] cpu_rdata,
    input logic              cpu_rdata_oe,
    input logic [WORD_W-1:0] dev_rdata,
    input logic [WORD_W-1:0] dev_wdata,
    input logic              dev_rd,
    input logic              dev_wr,
    input logic              err_orphan
);
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(dev_rd && dev_wr));

    assert_rd_one_clk_R6: assert property (@(posedge clk) disable iff (rst)
        dev_rd |=> !dev_rd);

    assert_wr_one_clk_R6: assert property (@(posedge clk) disable iff (rst)
        dev_wr |=> !dev_wr);

    assert_rd_lo_path_R1: assert property (@(posedge clk) disable iff (rst)
        dev_rd |-> (cpu_cs && cpu_stb && cpu_rw && !cpu_a0
                    && cpu_rdata == dev_rdata[BYTE_W-1:0]));

    assert_hi_from_hold_R2: assert property (@(posedge clk) disable iff (rst)
        dev_rd |=> (!(cpu_rdata_oe && cpu_a0)
                    || cpu_rdata == $past(dev_rdata[WORD_W-1:BYTE_W])));

    assert_wr_hi_path_R4: assert property (@(posedge clk) disable iff (rst)
        dev_wr |-> (cpu_cs && !cpu_rw && cpu_a0
                    && dev_wdata[WORD_W-1:BYTE_W] == cpu_wdata));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        err_orphan |=> err_orphan);

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !cpu_rdata_oe |-> (cpu_rdata == '0));

    assert_reset_clears_R7: assert property (@(posedge clk)
        $past(rst) |-> !err_orphan);
endmodule

bind bridge_8to16 br_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_cs       (cpu_cs),
    .cpu_rw       (cpu_rw),
    .cpu_a0       (cpu_a0),
    .cpu_stb      (cpu_stb),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata    (cpu_rdata),
    .cpu_rdata_oe (cpu_rdata_oe),
    .dev_rdata    (dev_rdata),
    .dev_wdata    (dev_wdata),
    .dev_rd       (dev_rd),
    .dev_wr       (dev_wr),
    .err_orphan   (err_orphan)
);

// File: tb/bridge_8to16_tb.sv
module bridge_8to16_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_cs = 1'b0, cpu_rw = 1'b0, cpu_a0 = 1'b0, cpu_stb = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rdata_oe;
    logic [15:0] dev_rdata = '0;
    logic [15:0] dev_wdata;
    logic        dev_rd, dev_wr, err_orphan;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // Reference model state.
    logic [7:0] m_hold = '0;
    bit m_pend = 0, m_err = 0, m_prev = 0;
    int rd_cnt = 0, wr_cnt = 0, both_cnt = 0;
    logic [7:0] last_rdata;

    always #2 clk = ~clk;

    bridge_8to16 u_dut (
        .clk(clk), .rst(rst), .cpu_cs(cpu_cs), .cpu_rw(cpu_rw), .cpu_a0(cpu_a0),
        .cpu_stb(cpu_stb), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rdata_oe(cpu_rdata_oe), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata),
        .dev_rd(dev_rd), .dev_wr(dev_wr), .err_orphan(err_orphan)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the behavioural model, then model update.
    always @(negedge clk) begin
        bit ev, e_rd, e_wr, e_oe;
        logic [7:0] e_rdata;
        if (dev_rd) rd_cnt++;
        if (dev_wr) wr_cnt++;
        if (dev_rd && dev_wr) both_cnt++;
        ev   = !rst && cpu_cs && cpu_stb && !m_prev;
        e_rd = ev && cpu_rw && !cpu_a0;
        e_wr = ev && !cpu_rw && cpu_a0 && m_pend;
        e_oe = cpu_cs && cpu_rw && cpu_stb;
        e_rdata = !e_oe ? 8'h00 : (cpu_a0 ? m_hold : dev_rdata[7:0]);
        chk("R1 dev_rd", int'(dev_rd), int'(e_rd));
        chk((ev && !cpu_rw && !cpu_a0) ? "R3 dev_wr" : "R4 dev_wr", int'(dev_wr), int'(e_wr));
        if (e_wr) chk("R4 dev_wdata", int'(dev_wdata), int'({cpu_wdata, m_hold}));
        chk("R8 oe", int'(cpu_rdata_oe), int'(e_oe));
        chk(cpu_a0 ? "R2 rdata" : "R1 rdata", int'(cpu_rdata), int'(e_rdata));
        chk("R5 err", int'(err_orphan), int'(m_err));
        if (rst) begin
            m_hold = '0; m_pend = 0; m_err = 0; m_prev = 0;
        end else begin
            m_prev = cpu_cs && cpu_stb;
            if (e_rd) begin m_hold = dev_rdata[15:8]; m_pend = 0; end
            if (ev && !cpu_rw && !cpu_a0) begin m_hold = cpu_wdata; m_pend = 1; end
            if (ev && !cpu_rw && cpu_a0) begin
                if (m_pend) m_pend = 0; else m_err = 1;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        dev_rdata = 16'($urandom);
    endtask

    task automatic access(input bit rw, input bit a0, input logic [7:0] wd,
                          input int len, input bit use_cs);
        cpu_cs = use_cs; cpu_stb = 1'b1; cpu_rw = rw; cpu_a0 = a0; cpu_wdata = wd;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) last_rdata = cpu_rdata;
            step();
        end
        cpu_cs = 1'b0; cpu_stb = 1'b0;
        step();
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0; step();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int r0, w0;
        do_reset();
        // R7: reset state
        chk("R7 err after reset", int'(err_orphan), 0);
        access(1, 1, 8'h00, 1, 1);
        chk("R7 hold cleared", int'(last_rdata), 0);

        // R1/R2: read pair, device word fixed
        dev_rdata = 16'hA55A; cpu_cs = 1; cpu_stb = 1; cpu_rw = 1; cpu_a0 = 0;
        @(negedge clk); chk("R1 low byte", int'(cpu_rdata), 8'h5A);
        @(posedge clk); #1; cpu_cs = 0; cpu_stb = 0; step();
        access(1, 1, 8'h00, 1, 1);
        chk("R2 high byte", int'(last_rdata), 8'hA5);

        // R3/R4: write pair
        w0 = wr_cnt;
        access(0, 0, 8'h34, 1, 1);
        chk("R3 no write on low", wr_cnt - w0, 0);
        access(0, 1, 8'h12, 1, 1);
        chk("R4 one write", wr_cnt - w0, 1);

        // R6: held strobe gives a single device read
        r0 = rd_cnt;
        access(1, 0, 8'h00, 4, 1);
        chk("R6 one read per held strobe", rd_cnt - r0, 1);

        // R9: low read cancels pending write
        w0 = wr_cnt;
        access(0, 0, 8'h77, 1, 1);
        access(1, 0, 8'h00, 1, 1);
        access(0, 1, 8'h66, 1, 1);
        chk("R9 cancelled write not issued", wr_cnt - w0, 0);
        chk("R9 orphan flagged", int'(err_orphan), 1);

        // R5: sticky until reset
        access(0, 0, 8'h01, 1, 1);
        access(0, 1, 8'h02, 1, 1);
        chk("R5 err stays", int'(err_orphan), 1);

        // R7: reset drops pending write
        do_reset();
        access(0, 0, 8'h99, 1, 1);
        do_reset();
        w0 = wr_cnt;
        access(0, 1, 8'h88, 1, 1);
        chk("R7 pending discarded", wr_cnt - w0, 0);
        chk("R5 orphan after reset", int'(err_orphan), 1);
        do_reset();

        // Random mix
        for (int k = 0; k < 400; k++) begin
            access(1'($urandom), 1'($urandom), 8'($urandom),
                   1 + int'($urandom % 3), ($urandom % 8) != 0);
            if ($urandom % 50 == 0) do_reset();
        end
        chk("R6 strobes never together", both_cnt, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule